// File: doc/BRIEF.md
# Channel fault event register

This block keeps a set of sticky fault flags for a four-channel power controller. For each channel it records two kinds of event. One is a current-limit timeout. The other is a start-up timeout, which also covers a failed detection or classification. Each event arrives as a one-cycle pulse and sets its flag, and the flag stays set until something clears it.

Software reads the flags through a command-addressed read strobe. One command code returns the flags and leaves them alone. A second code returns the same value and wipes every flag at the same clock edge. A flag is also cleared on its own when its channel reports that it has been switched off.

In auto mode, start flags raised only by a bad detection or classification result are ignored. A level interrupt request is raised while any enabled flag is set.

Top module: `chan_fault_latch`

## Requirements
- R1: After reset every flag is 0, `rd_data` is 0 and `irq` is low.
- R2: A read strobe with command 0x08 loads the current flags into `rd_data` at the next clock edge and changes no flag.
- R3: A read strobe with command 0x09 loads the flags as they were before that edge into `rd_data` and clears every flag at the same edge.
- R4: Flag positions are fixed:
  - bit 4+k is the current-limit timeout of channel k+1 (k = 0..3), set by `ilim_hit[k]`;
  - bit k is the start timeout of channel k+1, set by `start_hit[k]`;
  - a one-cycle pulse sets the flag at the next edge, and the flag stays set.
- R5: A start flag is also set by `disc_bad[k]` while `auto_mode` is 0. `start_hit[k]` sets it in either mode.
- R6: While `auto_mode` is 1, a `disc_bad` pulse leaves every flag unchanged.
- R7: `chan_off[k]` clears bits k and 4+k at the next edge and leaves the other channels' bits untouched. An event on the same channel in the same cycle does not survive the off.
- R8: An event arriving in the same cycle as a 0x09 read is not included in that read's data, and it is set after the clear.
- R9: `irq` is high exactly when some flag bit i is set with `irq_en[i]` high. It follows `irq_en` without a clock.
- R10: A read strobe with any other command code loads 0 into `rd_data` and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ilim_hit | input | 4 | Per-channel current-limit timeout pulse |
| start_hit | input | 4 | Per-channel start timeout pulse |
| disc_bad | input | 4 | Per-channel invalid detection/classification pulse |
| chan_off | input | 4 | Per-channel turned-off indication |
| auto_mode | input | 1 | Auto mode; suppresses `disc_bad` |
| rd_en | input | 1 | Read strobe |
| rd_cmd | input | 8 | Read command code |
| irq_en | input | 8 | Per-bit interrupt enable |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
Flag updates and read data each come one clock edge after the cycle that carries the pulse or strobe. `irq` follows a flag change in that same post-edge interval, and follows a change of `irq_en` with no edge at all.

The bench drives every input just after a rising edge and holds it for exactly one cycle. It samples one time unit after the next rising edge, so each result is read in the cycle it is due and before the following stimulus.

The clearing behaviour is only ever checked through a later 0x08 read. A contents-preserving 0x08 read therefore follows each clear or suppression.

// File: rtl/chan_fault_latch.sv
module chan_fault_latch #(
  parameter int NCH = 4,
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] CMD_PEEK = 'h08,
  parameter logic [CMD_W-1:0] CMD_POP = 'h09
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     ilim_hit,
  input  logic [NCH-1:0]     start_hit,
  input  logic [NCH-1:0]     disc_bad,
  input  logic [NCH-1:0]     chan_off,
  input  logic               auto_mode,
  input  logic               rd_en,
  input  logic [CMD_W-1:0]   rd_cmd,
  input  logic [2*NCH-1:0]   irq_en,
  output logic [2*NCH-1:0]   rd_data,
  output logic               irq
);
  localparam int FW = 2 * NCH;

  logic [FW-1:0] flags;

  wire peek = rd_en && (rd_cmd == CMD_PEEK);
  wire pop  = rd_en && (rd_cmd == CMD_POP);

  wire [NCH-1:0] strt_set = start_hit | (disc_bad & {NCH{~auto_mode}});
  wire [FW-1:0]  set_v    = {ilim_hit, strt_set};
  wire [FW-1:0]  off_v    = {chan_off, chan_off};
  wire [FW-1:0]  held     = pop ? '0 : flags;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (held | set_v) & ~off_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= (peek || pop) ? flags : '0;
  end

  assign irq = |(flags & irq_en);

  // R2
  a_r2_peek_data: assert property (@(posedge clk) disable iff (!rst_n)
    peek |=> rd_data == $past(flags));
  a_r2_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (peek && chan_off == '0) |=> (($past(flags) & ~flags) == '0));

  // R3
  a_r3_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && ilim_hit == '0 && start_hit == '0 && disc_bad == '0) |=> flags == '0 && !irq);

  // R6
  a_r6_auto_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && start_hit == '0 && flags[NCH-1:0] == '0) |=> flags[NCH-1:0] == '0);

  // R10
  a_r10_other_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !peek && !pop) |=> rd_data == '0);

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    // R7
    a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      chan_off[k] |=> !flags[k] && !flags[NCH+k]);
    // R8
    a_r8_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && ilim_hit[k] && !chan_off[k]) |=> flags[NCH+k]);
  end
endmodule

// File: tb/chan_fault_latch_test.sv
module chan_fault_latch_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [3:0] ilim_hit = 0, start_hit = 0, disc_bad = 0, chan_off = 0;
  logic auto_mode = 0, rd_en = 0;
  logic [7:0] rd_cmd = 0, irq_en = 8'hFF;
  logic [7:0] rd_data;
  logic irq;
  int n_chk = 0, n_bad = 0;

  chan_fault_latch uut (
    .clk(clk), .rst_n(rst_n), .ilim_hit(ilim_hit), .start_hit(start_hit),
    .disc_bad(disc_bad), .chan_off(chan_off), .auto_mode(auto_mode),
    .rd_en(rd_en), .rd_cmd(rd_cmd), .irq_en(irq_en),
    .rd_data(rd_data), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse(logic [3:0] il, logic [3:0] st, logic [3:0] db, logic [3:0] off);
    ilim_hit = il; start_hit = st; disc_bad = db; chan_off = off;
    step();
    ilim_hit = 0; start_hit = 0; disc_bad = 0; chan_off = 0;
  endtask

  task automatic rd(logic [7:0] cmd);
    rd_en = 1; rd_cmd = cmd;
    step();
    rd_en = 0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(8'h08); chk("R1 flags", rd_data, 8'h00);
  endtask

  task automatic t_layout();
    pulse(4'b0001, 0, 0, 0);
    rd(8'h08); chk("R4 ilim ch1 bit4", rd_data, 8'h10);
    pulse(0, 4'b1000, 0, 0);
    rd(8'h08); chk("R4 start ch4 bit3", rd_data, 8'h18);
    rd(8'h08); chk("R2 peek no side effect", rd_data, 8'h18);
  endtask

  task automatic t_pop();
    rd(8'h09); chk("R3 pop data", rd_data, 8'h18);
    chk("R3 irq after pop", {7'd0, irq}, 8'h00);
    rd(8'h08); chk("R3 cleared", rd_data, 8'h00);
  endtask

  task automatic t_disc();
    auto_mode = 0;
    pulse(0, 0, 4'b0010, 0);
    rd(8'h08); chk("R5 disc_bad manual", rd_data, 8'h02);
    rd(8'h09);
    auto_mode = 1;
    pulse(0, 0, 4'b0100, 0);
    rd(8'h08); chk("R6 disc_bad auto ignored", rd_data, 8'h00);
    chk("R6 irq stays low", {7'd0, irq}, 8'h00);
    pulse(0, 4'b0100, 0, 0);
    rd(8'h08); chk("R5 start_hit auto", rd_data, 8'h04);
    auto_mode = 0;
    rd(8'h09);
  endtask

  task automatic t_off();
    pulse(4'b1111, 4'b1111, 0, 0);
    rd(8'h08); chk("R4 all set", rd_data, 8'hFF);
    pulse(0, 0, 0, 4'b0010);
    rd(8'h08); chk("R7 ch2 off", rd_data, 8'hDD);
    pulse(4'b0100, 0, 0, 4'b0100);
    rd(8'h08); chk("R7 off beats event", rd_data, 8'h99);
  endtask

  task automatic t_race();
    ilim_hit = 4'b0001; rd_en = 1; rd_cmd = 8'h09;
    step();
    ilim_hit = 0; rd_en = 0;
    chk("R8 pop data excludes event", rd_data, 8'h99);
    rd(8'h08); chk("R8 event kept", rd_data, 8'h10);
  endtask

  task automatic t_irq();
    chk("R9 irq set", {7'd0, irq}, 8'h01);
    irq_en = 8'h0F; #1;
    chk("R9 irq masked", {7'd0, irq}, 8'h00);
    irq_en = 8'h10; #1;
    chk("R9 irq single enable", {7'd0, irq}, 8'h01);
    rd(8'h09);
    chk("R9 irq released by pop", {7'd0, irq}, 8'h00);
    irq_en = 8'hFF;
  endtask

  task automatic t_badcmd();
    pulse(0, 4'b0001, 0, 0);
    rd(8'h0A); chk("R10 other cmd data", rd_data, 8'h00);
    rd(8'h08); chk("R10 flags kept", rd_data, 8'h01);
  endtask

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_layout();
    t_pop();
    t_disc();
    t_off();
    t_race();
    t_irq();
    t_badcmd();
    summary();
  end
endmodule